// File: doc/BRIEF.md
# Audio Clock Regeneration N/CTS Generator

This block supplies the numerator/time-stamp pair that a display link sink needs to rebuild the audio sample clock from the link clock. The numerator N is a 20-bit value. It is either assembled from byte writes or taken from a built-in table of values for common pixel rates, including the fractional ones. The time stamp CTS is either a fixed value from byte writes or, when that value is zero, a measurement. The measurement counts link clock cycles across a window that is timed by an audio reference clock running at a selectable multiple of fs.

The reference clock side divides its edges into windows of N·M/128 edges, where M is the reference multiple. It flips a toggle at each window end. The toggle crosses into the link clock domain through a synchronizer, and each flip there closes a cycle count. The first window after a start is partial, so the block drops it. After that, every window yields one N/CTS pair with a single-cycle valid strobe.

Top module: `acr_ncts_gen`

## Requirements
- R1: While rst_ni is low, valid_o, n_o and cts_o are all zero.
- R2: Register addresses 0, 1 and 2 write bits 7:0, 15:8 and 19:16 of N respectively, least significant first. Bits 7:4 written at address 2 are dropped. N appears on n_o with each valid strobe.
- R3: With the fixed CTS at zero, cts_o equals the number of link clock cycles in W reference edges. W = floor(N·4·2^k/128), where k is the 3-bit ratio field written at address 6 (bits 2:0), so the reference clock is 4·2^k·fs and k = 4 means 64·fs.
- R4: CTS bytes are written at addresses 3, 4 and 5, least significant first. When the 20-bit CTS value is nonzero, cts_o carries it unchanged on every strobe, and window timing is unaffected.
- R5: Control bit 0 at address 7 is the audio clock disable. It resets to 1. While it is set, no strobe is produced, even with enable_i high and even if it is set during a run.
- R6: While enable_i is low, no strobe is produced.
- R7: After a start, the first window boundary only arms the measurement. Strobes are spaced by exactly one window of link cycles, and n_o and cts_o hold their values between strobes.
- R8: When control bit 1 at address 7 is set, N comes from rate_sel_i instead of the registers: 0 gives 6144, 1 gives 6864, 2 gives 11648 and 3 gives 5824 (48 kHz values for other, 25.17, 74.17 and 148.35 MHz pixel rates).
- R9: When N·4·2^k/128 rounds down to zero, the window is one reference edge long.
- R10: valid_o is high for exactly one link clock cycle per window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tmds_clk_i | input | 1 | Link (TMDS) clock; registers and outputs |
| aref_clk_i | input | 1 | Audio reference clock at 4·2^k·fs |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| enable_i | input | 1 | Run request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| rate_sel_i | input | 2 | Pixel-rate class for the N table |
| n_o | output | 20 | N of the current pair |
| cts_o | output | 20 | CTS of the current pair |
| valid_o | output | 1 | One-cycle strobe per window |

## Verification
The hardest state to reach is the exact count across the clock crossing. The window boundary travels through a toggle synchronizer, so the expected CTS only comes out deterministic when the two clocks keep a fixed relation. The bench runs the reference clock at exactly three link cycles per period, offset by 1 ns so no edges coincide. This makes every window exactly 3·W link cycles, which the bench computes from N and k. Each case sweeps the ratio field across all eight codes, drives N down to a zero-length window and up through the top byte lane, and stops runs mid-stream by dropping enable and by setting the clock-disable bit. These stops show that no stale toggle leaks out as a strobe.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int unsigned N_W    = 20;
  localparam int unsigned CTS_W  = 20;
  localparam int unsigned FS_W   = 3;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_N_B0   = 3'd0,
    A_N_B1   = 3'd1,
    A_N_B2   = 3'd2,
    A_CTS_B0 = 3'd3,
    A_CTS_B1 = 3'd4,
    A_CTS_B2 = 3'd5,
    A_FS     = 3'd6,
    A_CTRL   = 3'd7
  } acr_addr_e;

  // 48 kHz N values per pixel-rate class
  function automatic logic [19:0] preset_n(input logic [1:0] sel);
    case (sel)
      2'd1:    return 20'd6864;
      2'd2:    return 20'd11648;
      2'd3:    return 20'd5824;
      default: return 20'd6144;
    endcase
  endfunction
endpackage

// File: rtl/acr_sync_bit.sv
module acr_sync_bit #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/acr_cfg_regs.sv
module acr_cfg_regs #(
  parameter int unsigned N_W    = acr_pkg::N_W,
  parameter int unsigned CTS_W  = acr_pkg::CTS_W,
  parameter int unsigned FS_W   = acr_pkg::FS_W,
  parameter int unsigned ADDR_W = acr_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [N_W-1:0]    n_o,
  output logic [CTS_W-1:0]  cts_o,
  output logic [FS_W-1:0]   fs_code_o,
  output logic              clk_dis_o,
  output logic              preset_en_o
);
  import acr_pkg::*;

  localparam int unsigned N_BYTES = (N_W + 7) / 8;
  localparam int unsigned C_BYTES = (CTS_W + 7) / 8;

  logic [N_W-1:0]   n_q, n_d;
  logic [CTS_W-1:0] c_q, c_d;
  logic [FS_W-1:0]  fs_q;
  logic             dis_q, pre_q;

  // byte-lane merge; lanes past the field width fall off the top
  always_comb begin
    n_d = n_q;
    for (int b = 0; b < N_BYTES; b++) begin
      if (addr_i == ADDR_W'(int'(A_N_B0) + b)) begin
        n_d = (n_q & ~(N_W'(8'hff) << (8 * b)))
            | ((N_W'(wdata_i) << (8 * b)) & (N_W'(8'hff) << (8 * b)));
      end
    end
    c_d = c_q;
    for (int b = 0; b < C_BYTES; b++) begin
      if (addr_i == ADDR_W'(int'(A_CTS_B0) + b)) begin
        c_d = (c_q & ~(CTS_W'(8'hff) << (8 * b)))
            | ((CTS_W'(wdata_i) << (8 * b)) & (CTS_W'(8'hff) << (8 * b)));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= '0;
      c_q   <= '0;
      fs_q  <= '0;
      dis_q <= 1'b1;
      pre_q <= 1'b0;
    end else if (we_i) begin
      n_q <= n_d;
      c_q <= c_d;
      if (addr_i == A_FS)   fs_q <= wdata_i[FS_W-1:0];
      if (addr_i == A_CTRL) begin
        dis_q <= wdata_i[0];
        pre_q <= wdata_i[1];
      end
    end
  end

  assign n_o         = n_q;
  assign cts_o       = c_q;
  assign fs_code_o   = fs_q;
  assign clk_dis_o   = dis_q;
  assign preset_en_o = pre_q;
endmodule

// File: rtl/acr_ref_window.sv
module acr_ref_window #(
  parameter int unsigned WIN_W  = 22,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             tog_o
);
  logic             run_s;
  logic [WIN_W-1:0] cnt_q;
  logic             tog_q;

  acr_sync_bit #(.STAGES(STAGES)) u_run_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (run_i),
    .q_o   (run_s)
  );

  // win_len_i is quasi-static: it only changes while run is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (!run_s) begin
      cnt_q <= '0;
    end else if (cnt_q == win_len_i - WIN_W'(1)) begin
      cnt_q <= '0;
      tog_q <= ~tog_q;
    end else begin
      cnt_q <= cnt_q + WIN_W'(1);
    end
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/acr_cts_counter.sv
module acr_cts_counter #(
  parameter int unsigned N_W   = acr_pkg::N_W,
  parameter int unsigned CTS_W = acr_pkg::CTS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             bound_i,
  input  logic [CTS_W-1:0] cts_man_i,
  input  logic [N_W-1:0]   n_i,
  output logic [N_W-1:0]   n_o,
  output logic [CTS_W-1:0] cts_o,
  output logic             valid_o
);
  logic [CTS_W-1:0] cnt_q, cnt_inc;
  logic             armed_q;
  logic [N_W-1:0]   n_q;
  logic [CTS_W-1:0] cts_q;
  logic             vld_q;

  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + CTS_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      n_q     <= '0;
      cts_q   <= '0;
      vld_q   <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
    end else if (bound_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      vld_q   <= armed_q;
      if (armed_q) begin
        n_q   <= n_i;
        cts_q <= (cts_man_i != '0) ? cts_man_i : cnt_inc;
      end
    end else begin
      cnt_q <= cnt_inc;
      vld_q <= 1'b0;
    end
  end

  assign n_o     = n_q;
  assign cts_o   = cts_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/acr_ncts_gen.sv
module acr_ncts_gen #(
  parameter int unsigned N_W    = acr_pkg::N_W,
  parameter int unsigned CTS_W  = acr_pkg::CTS_W,
  parameter int unsigned FS_W   = acr_pkg::FS_W,
  parameter int unsigned ADDR_W = acr_pkg::ADDR_W,
  parameter int unsigned STAGES = 2
) (
  input  logic              tmds_clk_i,
  input  logic              aref_clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic [1:0]        rate_sel_i,
  output logic [N_W-1:0]    n_o,
  output logic [CTS_W-1:0]  cts_o,
  output logic              valid_o
);
  import acr_pkg::*;

  localparam int unsigned SHIFT_MAX = (1 << FS_W) + 1;
  localparam int unsigned SCALED_W  = N_W + SHIFT_MAX;
  localparam int unsigned WIN_W     = SCALED_W - 7;

  logic [N_W-1:0]   n_reg, n_sel;
  logic [CTS_W-1:0] cts_man;
  logic [FS_W-1:0]  fs_code;
  logic             clk_dis, preset_en, run;
  logic [WIN_W-1:0] win_raw, win_len_q;
  logic             tog_ref, tog_s, tog_prev_q, bound;

  acr_cfg_regs #(
    .N_W(N_W), .CTS_W(CTS_W), .FS_W(FS_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i      (tmds_clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .n_o        (n_reg),
    .cts_o      (cts_man),
    .fs_code_o  (fs_code),
    .clk_dis_o  (clk_dis),
    .preset_en_o(preset_en)
  );

  assign run   = enable_i & ~clk_dis;
  assign n_sel = preset_en ? N_W'(preset_n(rate_sel_i)) : n_reg;

  // window = N * 4 * 2^k / 128 reference edges, never zero
  assign win_raw = WIN_W'((SCALED_W'(n_sel) << (fs_code + 2)) >> 7);

  always_ff @(posedge tmds_clk_i or negedge rst_ni) begin
    if (!rst_ni) win_len_q <= WIN_W'(1);
    else         win_len_q <= (win_raw == '0) ? WIN_W'(1) : win_raw;
  end

  acr_ref_window #(.WIN_W(WIN_W), .STAGES(STAGES)) u_win (
    .clk_i    (aref_clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .win_len_i(win_len_q),
    .tog_o    (tog_ref)
  );

  acr_sync_bit #(.STAGES(STAGES)) u_tog_sync (
    .clk_i (tmds_clk_i),
    .rst_ni(rst_ni),
    .d_i   (tog_ref),
    .q_o   (tog_s)
  );

  always_ff @(posedge tmds_clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_prev_q <= 1'b0;
    else         tog_prev_q <= tog_s;
  end

  assign bound = tog_s ^ tog_prev_q;

  acr_cts_counter #(.N_W(N_W), .CTS_W(CTS_W)) u_cnt (
    .clk_i    (tmds_clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .bound_i  (bound),
    .cts_man_i(cts_man),
    .n_i      (n_sel),
    .n_o      (n_o),
    .cts_o    (cts_o),
    .valid_o  (valid_o)
  );
endmodule

// File: rtl/acr_ncts_gen_chk.sv
module acr_ncts_gen_chk #(
  parameter int unsigned N_W   = 20,
  parameter int unsigned CTS_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             clk_dis_i,
  input logic [CTS_W-1:0] cts_man_i,
  input logic             valid_i,
  input logic [N_W-1:0]   n_i,
  input logic [CTS_W-1:0] cts_i
);
  // R10
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  // R6
  strobe_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(enable_i));

  // R5
  strobe_needs_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !$past(clk_dis_i));

  // R4
  manual_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ($past(cts_man_i) != '0)) |-> (cts_i == $past(cts_man_i)));

  // R7
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ($stable(n_i) && $stable(cts_i)));
endmodule

bind acr_ncts_gen acr_ncts_gen_chk #(.N_W(N_W), .CTS_W(CTS_W)) u_chk (
  .clk_i    (tmds_clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .clk_dis_i(clk_dis),
  .cts_man_i(cts_man),
  .valid_i  (valid_o),
  .n_i      (n_o),
  .cts_i    (cts_o)
);

// File: tb/acr_ncts_gen_tb.sv
module acr_ncts_gen_tb_top;
  logic        tmds_clk = 1'b0;
  logic        aref_clk = 1'b0;
  logic        rst_ni   = 1'b0;
  logic        enable   = 1'b0;
  logic        we       = 1'b0;
  logic [2:0]  addr     = '0;
  logic [7:0]  wdata    = '0;
  logic [1:0]  rate_sel = '0;
  logic [19:0] n_o, cts_o;
  logic        valid_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  localparam int RATIO = 3; // link cycles per reference period

  always #2 tmds_clk = ~tmds_clk;
  initial begin
    #1;
    forever #6 aref_clk = ~aref_clk;
  end

  acr_ncts_gen dut_i (
    .tmds_clk_i (tmds_clk),
    .aref_clk_i (aref_clk),
    .rst_ni     (rst_ni),
    .enable_i   (enable),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .rate_sel_i (rate_sel),
    .n_o        (n_o),
    .cts_o      (cts_o),
    .valid_o    (valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge tmds_clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge tmds_clk);
    we = 1'b0;
  endtask

  task automatic set_n(input int n);
    wr(3'd0, 8'(n));
    wr(3'd1, 8'(n >> 8));
    wr(3'd2, 8'(n >> 16));
  endtask

  task automatic set_cts(input int c);
    wr(3'd3, 8'(c));
    wr(3'd4, 8'(c >> 8));
    wr(3'd5, 8'(c >> 16));
  endtask

  function automatic int win(input int n, input int k);
    int w;
    w = (n * (4 << k)) / 128;
    return (w == 0) ? 1 : w;
  endfunction

  task automatic wait_valid(output int cyc);
    cyc = 0;
    while (!valid_o && cyc < 60000) begin
      @(negedge tmds_clk);
      cyc++;
    end
  endtask

  task automatic quiet(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge tmds_clk);
      if (valid_o) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic run_case(input int exp_n, input int exp_cts, input int exp_gap, input string req);
    int t, gap;
    @(negedge tmds_clk);
    enable = 1'b1;
    wait_valid(t);
    chk(t >= exp_gap, {req, " R7 first boundary armed only"}, t, exp_gap);
    chk(n_o == 20'(exp_n), {req, " n_o"}, int'(n_o), exp_n);
    chk(cts_o == 20'(exp_cts), {req, " cts_o"}, int'(cts_o), exp_cts);
    @(negedge tmds_clk);
    chk(!valid_o, {req, " R10 one-cycle strobe"}, int'(valid_o), 0);
    gap = 1;
    while (!valid_o && gap < 60000) begin
      @(negedge tmds_clk);
      gap++;
    end
    chk(gap == exp_gap, {req, " R7 strobe spacing"}, gap, exp_gap);
    chk(cts_o == 20'(exp_cts), {req, " cts_o second"}, int'(cts_o), exp_cts);
    enable = 1'b0;
    repeat (40) @(negedge tmds_clk);
  endtask

  initial begin
    int t;
    repeat (5) @(negedge tmds_clk);
    chk(!valid_o, "R1 valid", int'(valid_o), 0);
    chk(n_o == '0, "R1 n", int'(n_o), 0);
    chk(cts_o == '0, "R1 cts", int'(cts_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge tmds_clk);

    // clock disable held from reset
    set_n(256);
    wr(3'd6, 8'd4);
    @(negedge tmds_clk);
    enable = 1'b1;
    quiet(1500, "R5 clock disable out of reset");
    enable = 1'b0;
    repeat (20) @(negedge tmds_clk);

    wr(3'd7, 8'h00);
    run_case(256, RATIO * win(256, 4), RATIO * win(256, 4), "R3 k=4 64fs");

    // R3: full ratio sweep
    for (int k = 0; k < 8; k++) begin
      wr(3'd6, 8'(k));
      run_case(256, RATIO * win(256, k), RATIO * win(256, k), $sformatf("R3 k=%0d", k));
    end

    // R2: byte lanes, top nibble of byte 2 dropped
    wr(3'd6, 8'd0);
    set_n(769);
    run_case(769, RATIO * win(769, 0), RATIO * win(769, 0), "R2 lanes 0-1");
    wr(3'd0, 8'h80); wr(3'd1, 8'h00); wr(3'd2, 8'hF1);
    run_case(32'h10080, RATIO * win(32'h10080, 0), RATIO * win(32'h10080, 0), "R2 top lane");

    // R9: zero window rounds up to one reference edge
    set_n(16);
    run_case(16, RATIO, RATIO, "R9 n=16");
    set_n(0);
    run_case(0, RATIO, RATIO, "R9 n=0");

    // R4: fixed CTS passes through
    set_n(256);
    wr(3'd6, 8'd4);
    set_cts(32'h12345);
    run_case(256, 32'h12345, RATIO * win(256, 4), "R4 manual");
    set_cts(1);
    run_case(256, 1, RATIO * win(256, 4), "R4 manual one");
    set_cts(0);
    run_case(256, RATIO * win(256, 4), RATIO * win(256, 4), "R4 back to auto");

    // R8: N table
    wr(3'd7, 8'h02);
    wr(3'd6, 8'd0);
    begin
      int tbl[4] = '{6144, 6864, 11648, 5824};
      for (int s = 0; s < 4; s++) begin
        rate_sel = 2'(s);
        run_case(tbl[s], RATIO * win(tbl[s], 0), RATIO * win(tbl[s], 0),
                 $sformatf("R8 sel=%0d", s));
      end
    end

    // R6: drop enable mid-run
    wr(3'd7, 8'h00);
    set_n(256);
    wr(3'd6, 8'd4);
    @(negedge tmds_clk);
    enable = 1'b1;
    wait_valid(t);
    chk(valid_o, "R6 run before stop", int'(valid_o), 1);
    @(negedge tmds_clk);
    enable = 1'b0;
    quiet(1500, "R6 enable low");

    // R5: set clock disable mid-run
    enable = 1'b1;
    wait_valid(t);
    chk(valid_o, "R5 run before disable", int'(valid_o), 1);
    wr(3'd7, 8'h01);
    quiet(1500, "R5 clock disable mid-run");
    enable = 1'b0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge tmds_clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule